// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps processor time. It holds two 64-bit up-counters: a main time base and an alternate one that runs beside it. It also holds a 32-bit down-counting decrementer. All three move by one on each cycle in which the shared `tick` input is high. A run input can freeze the two time bases and later release them. While they are frozen the decrementer keeps counting.

Software reaches every counter through one register port. The port has a single-cycle write strobe with a select and data, and a separate combinational read select. Each time base is written and read as two independent 32-bit halves. A masked view of the main lower word serves code that expects a coarse real-time-clock style value. The decrementer interrupt is raised in two cases: when the count runs from zero to all-ones, and when software writes a negative value over a non-negative one. The interrupt holds until it is acknowledged.

Top module: `timebase_decr`

## Requirements
- R1: With `tick`=1 and `tb_run`=1, each time base adds one per clock over its full 64 bits, so the lower word carries into the upper word.
- R2: A write with select 0 (main) or 2 (alternate) replaces bits 31:0 of that time base and leaves bits 63:32 unchanged.
- R3: A write with select 1 (main) or 3 (alternate) replaces bits 63:32 of that time base and leaves bits 31:0 unchanged.
- R4: While `tb_run`=0 both time bases hold their values whatever `tick` does. Once `tb_run` returns to 1 they count on from those held values.
- R5: The decrementer (select 4) drops by one on every clock with `tick`=1, whatever the level of `tb_run`.
- R6: A tick while the decrementer is 0 loads 0xFFFFFFFF and sets `dec_irq`. Counting then continues down from all-ones.
- R7: A decrementer write sets `dec_irq` when written bit 31 is 1 and the current bit 31 is 0. Writing a negative value over a negative value does not set it, and neither does writing a non-negative value.
- R8: `dec_irq` stays set until a cycle with `dec_ack`=1 clears it. A new decrementer event in the same cycle as the acknowledge leaves it set.
- R9: After reset both time bases read 0, the decrementer reads 0xFFFFFFFF and `dec_irq` is 0.
- R10: Select 5 reads the main lower word ANDed with 0x3FFFFF80. A write through select 5 stores the write data ANDed with 0x3FFFFF80 into main bits 31:0 and keeps main bits 63:32.
- R11: A write lands on the next clock edge. When a tick comes in the same cycle, the written counter takes the write value and skips that tick, while the other counters still take it.
- R12: Selects 6 and 7 read 0, and writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable shared by all counters |
| tb_run | input | 1 | 1 lets both time bases count, 0 freezes them |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read source select |
| rd_data | output | 32 | Live value of the selected register |
| dec_ack | input | 1 | Clears the decrementer interrupt |
| dec_irq | output | 1 | Sticky decrementer interrupt |

## Verification
The bench targets these corner cases:

- **Carry across the halves.** A time base loaded to 0x00000000_FFFFFFFE is run through the carry. A design that counted each half on its own would read the wrong upper word.
- **Freeze leaking into the decrementer.** The decrementer keeps counting while the time bases are frozen. A design that tied it to the run input would show a stale decrementer value.
- **Sign transitions.** Writing negative over negative must raise nothing. The wrap from zero must raise the interrupt and keep counting. An acknowledge that lands together with a new wrap must leave the interrupt set; a design that let the acknowledge win would drop that event.
- **Write and tick in the same cycle.** A written counter must hold exactly the written value, while its neighbour advances. The masked view and the unmapped selects are read back to show they store and return only what is allowed.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

    localparam int SEL_W = 3;

    // Register select codes used by both the write and the read port
    typedef enum logic [SEL_W-1:0] {
        SEL_TB_LO  = 3'd0,
        SEL_TB_HI  = 3'd1,
        SEL_ALT_LO = 3'd2,
        SEL_ALT_HI = 3'd3,
        SEL_DEC    = 3'd4,
        SEL_RTC_LO = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/tb_counter.sv
// One 64-bit time base with independently writable halves.
module tb_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wr_val,
    output logic [2*HALF_W-1:0] count
);
    localparam int FULL_W = 2 * HALF_W;

    typedef struct packed {
        logic [FULL_W-1:0] cnt;
    } tbc_state_t;

    tbc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            // a write owns this counter for the cycle; any tick is dropped
            if (wr_lo) st_d.cnt[HALF_W-1:0]      = wr_val;
            if (wr_hi) st_d.cnt[FULL_W-1:HALF_W] = wr_val;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + FULL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_lo && !wr_hi) |=> (st_q.cnt == $past(st_q.cnt) + FULL_W'(1))); // R1
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (st_q.cnt[FULL_W-1:HALF_W] == $past(st_q.cnt[FULL_W-1:HALF_W]))); // R2
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (st_q.cnt[HALF_W-1:0] == $past(st_q.cnt[HALF_W-1:0]))); // R3
    AST_TB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_lo && !wr_hi) |=> $stable(st_q.cnt)); // R4
    AST_WR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && adv) |=> (st_q.cnt[HALF_W-1:0] == $past(wr_val))); // R11

endmodule

// File: rtl/dec_unit.sv
// Down-counting decrementer with a sticky sign-transition interrupt.
module dec_unit #(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [DEC_W-1:0] wr_val,
    input  logic             ack,
    output logic [DEC_W-1:0] count,
    output logic             irq
);
    localparam int MSB = DEC_W - 1;

    typedef struct packed {
        logic [DEC_W-1:0] cnt;
        logic             irq;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (wr) begin
            st_d.cnt = wr_val;
            fire     = wr_val[MSB] && !st_q.cnt[MSB];
        end else if (tick) begin
            st_d.cnt = st_q.cnt - DEC_W'(1);
            fire     = (st_q.cnt == '0);
        end
        // a fresh event outranks an acknowledge in the same cycle
        st_d.irq = fire || (st_q.irq && !ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign irq   = st_q.irq;

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr) |=> (st_q.cnt == $past(st_q.cnt) - DEC_W'(1))); // R5
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && st_q.cnt == '0) |=> (st_q.cnt == '1 && st_q.irq)); // R6
    AST_NEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_val[MSB] && !st_q.cnt[MSB]) |=> st_q.irq); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !ack) |=> st_q.irq); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(tick || wr)); // R7

endmodule

// File: rtl/timebase_decr.sv
module timebase_decr
    import tbdec_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tb_run,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dec_ack,
    output logic              dec_irq
);
    localparam int TB_W   = 2 * DATA_W;
    localparam int NUM_TB = 2;   // index 0 main, 1 alternate

    logic              tb_wr_lo  [NUM_TB];
    logic              tb_wr_hi  [NUM_TB];
    logic [DATA_W-1:0] tb_wr_val [NUM_TB];
    logic [TB_W-1:0]   tb_cnt    [NUM_TB];
    logic              tb_adv;
    logic              dec_wr;
    logic [DATA_W-1:0] dec_cnt;

    assign tb_adv = tick && tb_run;
    assign dec_wr = wr_en && (wr_sel == SEL_DEC);

    always_comb begin
        tb_wr_lo[0]  = wr_en && (wr_sel == SEL_TB_LO || wr_sel == SEL_RTC_LO);
        tb_wr_hi[0]  = wr_en && (wr_sel == SEL_TB_HI);
        tb_wr_val[0] = (wr_sel == SEL_RTC_LO) ? (wr_data & RTC_MASK) : wr_data;
        tb_wr_lo[1]  = wr_en && (wr_sel == SEL_ALT_LO);
        tb_wr_hi[1]  = wr_en && (wr_sel == SEL_ALT_HI);
        tb_wr_val[1] = wr_data;
    end

    for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
        tb_counter #(.HALF_W(DATA_W)) u_tb (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (tb_adv),
            .wr_lo  (tb_wr_lo[g]),
            .wr_hi  (tb_wr_hi[g]),
            .wr_val (tb_wr_val[g]),
            .count  (tb_cnt[g])
        );
    end

    dec_unit #(.DEC_W(DATA_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr     (dec_wr),
        .wr_val (wr_data),
        .ack    (dec_ack),
        .count  (dec_cnt),
        .irq    (dec_irq)
    );

    always_comb begin
        case (rd_sel)
            SEL_TB_LO:  rd_data = tb_cnt[0][DATA_W-1:0];
            SEL_TB_HI:  rd_data = tb_cnt[0][TB_W-1:DATA_W];
            SEL_ALT_LO: rd_data = tb_cnt[1][DATA_W-1:0];
            SEL_ALT_HI: rd_data = tb_cnt[1][TB_W-1:DATA_W];
            SEL_DEC:    rd_data = dec_cnt;
            SEL_RTC_LO: rd_data = tb_cnt[0][DATA_W-1:0] & RTC_MASK;
            default:    rd_data = '0;
        endcase
    end

    AST_RTC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_RTC_LO) |-> ((rd_data & ~RTC_MASK) == '0)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel > SEL_RTC_LO) |-> (rd_data == '0)); // R12
    AST_ONE_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tb_wr_lo[0] && tb_wr_hi[0]) && !(tb_wr_lo[1] && tb_wr_hi[1])); // R2

endmodule

// File: tb/timebase_decr_bench.sv
module timebase_decr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        tb_run = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        dec_ack = 1'b0;
    logic        dec_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    timebase_decr u_timebase_decr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tb_run(tb_run),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .dec_ack(dec_ack), .dec_irq(dec_irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [2:0]  sel;
        logic [31:0] data;   // write data, or expected read value
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 32'h1234_5678},  // R2 main low write
        '{1'b0, 3'd0, 32'h1234_5678},  // R2
        '{1'b0, 3'd1, 32'h0000_0000},  // R2 upper untouched
        '{1'b1, 3'd1, 32'hCAFE_F00D},  // R3 main high write
        '{1'b0, 3'd0, 32'h1234_5678},  // R3 lower untouched
        '{1'b0, 3'd1, 32'hCAFE_F00D},  // R3
        '{1'b1, 3'd2, 32'hA5A5_A5A5},  // R2 alternate low
        '{1'b0, 3'd2, 32'hA5A5_A5A5},  // R2
        '{1'b0, 3'd0, 32'h1234_5678},  // R2 main unaffected
        '{1'b1, 3'd5, 32'hFFFF_FFFF},  // R10 masked write
        '{1'b0, 3'd0, 32'h3FFF_FF80},  // R10
        '{1'b0, 3'd1, 32'hCAFE_F00D},  // R10 upper kept
        '{1'b0, 3'd5, 32'h3FFF_FF80},  // R10 masked read
        '{1'b1, 3'd6, 32'h1111_1111},  // R12 unmapped write
        '{1'b0, 3'd6, 32'h0000_0000},  // R12
        '{1'b0, 3'd0, 32'h3FFF_FF80},  // R12 nothing changed
        '{1'b0, 3'd7, 32'h0000_0000}   // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [31:0] alt_prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        rd_check("R9", 3'd0, 32'h0);
        rd_check("R9", 3'd1, 32'h0);
        rd_check("R9", 3'd2, 32'h0);
        rd_check("R9", 3'd3, 32'h0);
        rd_check("R9", 3'd4, 32'hFFFF_FFFF);
        check("R9", {31'b0, dec_irq}, 32'h0);

        // table walk, no ticks
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_wr) do_write(VECS[i].sel, VECS[i].data);
            else               rd_check("table", VECS[i].sel, VECS[i].data);
        end

        // R1 carry across halves
        do_write(3'd1, 32'h0);
        do_write(3'd0, 32'hFFFF_FFFE);
        do_write(3'd4, 32'h0000_0010);
        run_ticks(3);
        rd_check("R1", 3'd0, 32'h0000_0001);
        rd_check("R1", 3'd1, 32'h0000_0001);
        rd_check("R1", 3'd2, 32'hA5A5_A5A8);
        rd_check("R5", 3'd4, 32'h0000_000D);

        // R4 freeze, R5 decrementer keeps going
        tb_run = 1'b0;
        run_ticks(5);
        rd_check("R4", 3'd0, 32'h0000_0001);
        rd_check("R4", 3'd2, 32'hA5A5_A5A8);
        rd_check("R5", 3'd4, 32'h0000_0008);
        tb_run = 1'b1;
        run_ticks(2);
        rd_check("R4", 3'd0, 32'h0000_0003);
        rd_check("R4", 3'd1, 32'h0000_0001);

        // R6 wrap through zero
        do_write(3'd1 + 3'd3, 32'h0000_0001);
        run_ticks(1);
        rd_check("R6", 3'd4, 32'h0);
        check("R6", {31'b0, dec_irq}, 32'h0);
        run_ticks(1);
        rd_check("R6", 3'd4, 32'hFFFF_FFFF);
        check("R6", {31'b0, dec_irq}, 32'h1);
        run_ticks(1);
        rd_check("R6", 3'd4, 32'hFFFF_FFFE);
        check("R8", {31'b0, dec_irq}, 32'h1);   // still held

        // R8 acknowledge
        @(negedge clk); dec_ack = 1'b1;
        @(negedge clk); dec_ack = 1'b0;
        check("R8", {31'b0, dec_irq}, 32'h0);

        // R7 negative over negative, then positive, then negative over positive
        do_write(3'd4, 32'h8000_0000);
        check("R7", {31'b0, dec_irq}, 32'h0);
        rd_check("R7", 3'd4, 32'h8000_0000);
        do_write(3'd4, 32'h0000_0005);
        check("R7", {31'b0, dec_irq}, 32'h0);
        do_write(3'd4, 32'h9000_0000);
        check("R7", {31'b0, dec_irq}, 32'h1);

        // R8 event together with acknowledge keeps the flag
        do_write(3'd4, 32'h0);
        check("R8", {31'b0, dec_irq}, 32'h1);
        @(negedge clk); tick = 1'b1; dec_ack = 1'b1;
        @(negedge clk); tick = 1'b0; dec_ack = 1'b0;
        check("R8", {31'b0, dec_irq}, 32'h1);
        rd_check("R8", 3'd4, 32'hFFFF_FFFF);
        @(negedge clk); dec_ack = 1'b1;
        @(negedge clk); dec_ack = 1'b0;
        check("R8", {31'b0, dec_irq}, 32'h0);

        // R11 write and tick in the same cycle
        rd_sel = 3'd2; #1; alt_prev = rd_data;
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0000_0100;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd_check("R11", 3'd0, 32'h0000_0100);
        rd_check("R11", 3'd1, 32'h0000_0001);
        rd_check("R11", 3'd2, alt_prev + 32'h1);
        rd_check("R11", 3'd4, 32'hFFFF_FFFE);

        finish_run();
    end

endmodule